// File: doc/BRIEF.md
# Integer Register File with Deferred-Fault Poison Bits

This block is the integer register file of an in-order execution core that supports speculation. It has a configurable number of 64-bit entries, 128 by default, and each entry carries one poison bit. A set poison bit means the value came from a speculative operation whose fault was deferred, so the value cannot be trusted yet. The file has two combinational read ports and one write port. The write port stores a value together with its poison bit.

A small combine path sits on the two read ports. It applies one of four operations to the two operands and shows how poison moves into a result: the result is poisoned when either operand is poisoned. When an instruction cannot accept poisoned operands, the issuing logic raises a check request. If either operand is then poisoned, the block answers with a fault pulse.

Entry 0 is the constant zero. A write aimed at entry 0 is an architectural error: the file keeps its contents and an exception pulse is raised. Each read port also reports whether its address falls in the upper, stacked part of the file.

Top module: `int_regfile_nat`

## Requirements
- R1: Reading entry 0 on either port returns data 0 with the poison bit clear, at all times.
- R2: A write request to entry 0 leaves every entry unchanged. On the clock edge after the request, `wr_zero_exc` rises, and it stays high for exactly one cycle.
- R3: A write request to any nonzero entry stores `wr_data` and `wr_nat` at the clock edge. The stored value and poison bit read back on every later cycle until that entry is written again.
- R4: When a port reads the entry being written in the same cycle, it returns the incoming data and poison bit (write-first). Entry 0 is excluded from this.
- R5: `res_nat` is the OR of the two read-port poison bits. `res_data` depends on `op_sel`: 0 gives port0 + port1, 1 gives port0 − port1, 2 gives bitwise AND, and 3 gives bitwise XOR. All results are modulo 2^64.
- R6: When `chk_en` is high and either read-port poison bit is set, `nat_fault` is high for exactly the next cycle. Otherwise `nat_fault` stays low.
- R7: `rd0_stacked` and `rd1_stacked` are high exactly when their port's address is 32 or more.
- R8: Reset clears every stored value and every poison bit to 0, and clears both pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 7 | Write entry index |
| wr_data | input | 64 | Write value |
| wr_nat | input | 1 | Write poison bit |
| rd0_addr | input | 7 | Port 0 entry index |
| rd1_addr | input | 7 | Port 1 entry index |
| op_sel | input | 2 | Combine operation select |
| chk_en | input | 1 | Current consumer forbids poisoned operands |
| rd0_data | output | 64 | Port 0 value |
| rd0_nat | output | 1 | Port 0 poison bit |
| rd1_data | output | 64 | Port 1 value |
| rd1_nat | output | 1 | Port 1 poison bit |
| rd0_stacked | output | 1 | Port 0 address is in the stacked region |
| rd1_stacked | output | 1 | Port 1 address is in the stacked region |
| res_data | output | 64 | Combine result |
| res_nat | output | 1 | Combine result poison bit |
| wr_zero_exc | output | 1 | Pulse: an entry-0 write was attempted |
| nat_fault | output | 1 | Pulse: a poisoned operand reached a checking consumer |

## Verification
Two functions can fall in the same cycle: a write and a read of the same entry. A write that carries fresh poison then meets a consumer check on that same entry, so the bypassed poison has to decide the fault and the combine result. The random stimulus often points read addresses at the current write address, and poison is set on about a quarter of the writes. The bench judges each cycle against a reference array that it updates only at the clock edge. The expected read is the bypassed value when the addresses match, and the expected fault pulse is compared one cycle later.

// File: rtl/int_rf_pkg.sv
package int_rf_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_AND = 2'd2,
      OP_XOR = 2'd3
   } comb_op_e;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
   parameter int NUM_REGS = 128,
   parameter int DATA_W   = 64,
   parameter int RD_PORTS = 2,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic                           wr_nat,
   input  logic [RD_PORTS-1:0][ADDR_W-1:0] rd_addr,
   output logic [RD_PORTS-1:0][DATA_W-1:0] rd_data,
   output logic [RD_PORTS-1:0]             rd_nat
);
   logic [DATA_W-1:0] val_q [NUM_REGS];
   logic              nat_q [NUM_REGS];
   logic              wr_ok;

   // entry 0 is never written
   assign wr_ok = wr_en && (wr_addr != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            val_q[i] <= '0;
            nat_q[i] <= 1'b0;
         end
      end else if (wr_ok) begin
         val_q[wr_addr] <= wr_data;
         nat_q[wr_addr] <= wr_nat;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      always_comb begin
         if (rd_addr[p] == '0) begin
            rd_data[p] = '0;
            rd_nat[p]  = 1'b0;
         end else if (wr_ok && (wr_addr == rd_addr[p])) begin
            rd_data[p] = wr_data;
            rd_nat[p]  = wr_nat;
         end else begin
            rd_data[p] = val_q[rd_addr[p]];
            rd_nat[p]  = nat_q[rd_addr[p]];
         end
      end
   end
endmodule

// File: rtl/rf_combine.sv
module rf_combine
   import int_rf_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a_data,
   input  logic              a_nat,
   input  logic [DATA_W-1:0] b_data,
   input  logic              b_nat,
   input  comb_op_e          op,
   output logic [DATA_W-1:0] y_data,
   output logic              y_nat
);
   always_comb begin
      unique case (op)
         OP_ADD:  y_data = a_data + b_data;
         OP_SUB:  y_data = a_data - b_data;
         OP_AND:  y_data = a_data & b_data;
         default: y_data = a_data ^ b_data;
      endcase
      y_nat = a_nat | b_nat;
   end
endmodule

// File: rtl/rf_event_pulse.sv
module rf_event_pulse #(
   parameter int N_EVT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_req,
   output logic [N_EVT-1:0] evt_pulse
);
   for (genvar e = 0; e < N_EVT; e++) begin : g_evt
      always_ff @(posedge clk) begin
         if (!rst_n) evt_pulse[e] <= 1'b0;
         else        evt_pulse[e] <= evt_req[e];
      end
   end
endmodule

// File: rtl/int_regfile_nat.sv
module int_regfile_nat
   import int_rf_pkg::*;
#(
   parameter int NUM_REGS    = 128,
   parameter int DATA_W      = 64,
   parameter int STATIC_REGS = 32,
   localparam int ADDR_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_nat,
   input  logic [ADDR_W-1:0] rd0_addr,
   input  logic [ADDR_W-1:0] rd1_addr,
   input  logic [1:0]        op_sel,
   input  logic              chk_en,
   output logic [DATA_W-1:0] rd0_data,
   output logic              rd0_nat,
   output logic [DATA_W-1:0] rd1_data,
   output logic              rd1_nat,
   output logic              rd0_stacked,
   output logic              rd1_stacked,
   output logic [DATA_W-1:0] res_data,
   output logic              res_nat,
   output logic              wr_zero_exc,
   output logic              nat_fault
);
   if (NUM_REGS < 2 || (1 << ADDR_W) != NUM_REGS) begin : g_bad_depth
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (STATIC_REGS < 1 || STATIC_REGS > NUM_REGS) begin : g_bad_static
      $error("STATIC_REGS must lie in 1..NUM_REGS");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [1:0][ADDR_W-1:0] rd_addr;
   logic [1:0][DATA_W-1:0] rd_data;
   logic [1:0]             rd_nat;
   logic [1:0]             evt_req;
   logic [1:0]             evt_pulse;

   assign rd_addr = {rd1_addr, rd0_addr};

   rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RD_PORTS(2)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_nat(wr_nat),
      .rd_addr(rd_addr), .rd_data(rd_data), .rd_nat(rd_nat)
   );

   assign rd0_data = rd_data[0];
   assign rd1_data = rd_data[1];
   assign rd0_nat  = rd_nat[0];
   assign rd1_nat  = rd_nat[1];

   assign rd0_stacked = (rd0_addr >= ADDR_W'(STATIC_REGS));
   assign rd1_stacked = (rd1_addr >= ADDR_W'(STATIC_REGS));

   rf_combine #(.DATA_W(DATA_W)) u_comb (
      .a_data(rd_data[0]), .a_nat(rd_nat[0]),
      .b_data(rd_data[1]), .b_nat(rd_nat[1]),
      .op(comb_op_e'(op_sel)),
      .y_data(res_data), .y_nat(res_nat)
   );

   assign evt_req[0] = wr_en && (wr_addr == '0);
   assign evt_req[1] = chk_en && (rd_nat[0] || rd_nat[1]);

   rf_event_pulse #(.N_EVT(2)) u_evt (
      .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .evt_pulse(evt_pulse)
   );

   assign wr_zero_exc = evt_pulse[0];
   assign nat_fault   = evt_pulse[1];
endmodule

// File: rtl/rf_nat_checker.sv
module rf_nat_checker #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_nat,
   input logic [ADDR_W-1:0] rd0_addr,
   input logic [ADDR_W-1:0] rd1_addr,
   input logic              chk_en,
   input logic [DATA_W-1:0] rd0_data,
   input logic              rd0_nat,
   input logic [DATA_W-1:0] rd1_data,
   input logic              rd1_nat,
   input logic              res_nat,
   input logic              wr_zero_exc,
   input logic              nat_fault
);
   a_r1_zero_read0: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_addr == '0) |-> (rd0_data == '0 && !rd0_nat));
   a_r1_zero_read1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd1_addr == '0) |-> (rd1_data == '0 && !rd1_nat));
   a_r2_exc_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |=> wr_zero_exc);
   a_r2_exc_cause: assert property (@(posedge clk) disable iff (!rst_n)
      wr_zero_exc |-> $past(wr_en && wr_addr == '0));
   a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0 && rd0_addr == wr_addr) |-> (rd0_data == wr_data && rd0_nat == wr_nat));
   a_r5_nat_spread: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_nat || rd1_nat) |-> res_nat);
   a_r6_fault_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && (rd0_nat || rd1_nat)) |=> nat_fault);
   a_r6_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
      nat_fault |-> $past(chk_en && (rd0_nat || rd1_nat)));
endmodule

bind int_regfile_nat rf_nat_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .wr_nat(wr_nat), .rd0_addr(rd0_addr), .rd1_addr(rd1_addr), .chk_en(chk_en),
   .rd0_data(rd0_data), .rd0_nat(rd0_nat), .rd1_data(rd1_data), .rd1_nat(rd1_nat),
   .res_nat(res_nat), .wr_zero_exc(wr_zero_exc), .nat_fault(nat_fault)
);

// File: tb/int_regfile_nat_tb.sv
`timescale 1ns/1ps
module int_regfile_nat_tb;
   localparam int NR = 128;
   localparam int DW = 64;
   localparam int AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, wr_nat = 1'b0, chk_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd0_addr = '0, rd1_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0]    op_sel = '0;
   logic [DW-1:0] rd0_data, rd1_data, res_data;
   logic          rd0_nat, rd1_nat, rd0_stacked, rd1_stacked, res_nat, wr_zero_exc, nat_fault;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   logic [DW-1:0] m_val [NR];
   logic          m_nat [NR];
   logic          exp_exc = 1'b0, exp_fault = 1'b0;

   always #2.5 clk = ~clk;

   int_regfile_nat u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_nat(wr_nat), .rd0_addr(rd0_addr), .rd1_addr(rd1_addr), .op_sel(op_sel),
      .chk_en(chk_en), .rd0_data(rd0_data), .rd0_nat(rd0_nat), .rd1_data(rd1_data),
      .rd1_nat(rd1_nat), .rd0_stacked(rd0_stacked), .rd1_stacked(rd1_stacked),
      .res_data(res_data), .res_nat(res_nat), .wr_zero_exc(wr_zero_exc), .nat_fault(nat_fault)
   );

   function automatic logic [DW-1:0] f_comb(logic [DW-1:0] a, logic [DW-1:0] b, logic [1:0] op);
      case (op)
         2'd0:    return a + b;
         2'd1:    return a - b;
         2'd2:    return a & b;
         default: return a ^ b;
      endcase
   endfunction

   function automatic logic [DW:0] f_read(logic [AW-1:0] a);
      if (a == '0) return '0;
      if (wr_en && wr_addr == a) return {wr_nat, wr_data};
      return {m_nat[a], m_val[a]};
   endfunction

   task automatic chk(string req, logic [DW:0] act, logic [DW:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
      end
   endtask

   // drive at negedge, check combinational outputs, then let the edge update the model
   task automatic step(logic we, logic [AW-1:0] wa, logic [DW-1:0] wd, logic wn,
                       logic [AW-1:0] a0, logic [AW-1:0] a1, logic [1:0] op, logic ce);
      logic [DW:0] e0, e1;
      chk("R2 exc pulse", {64'd0, wr_zero_exc}, {64'd0, exp_exc});
      chk("R6 fault pulse", {64'd0, nat_fault}, {64'd0, exp_fault});
      wr_en = we; wr_addr = wa; wr_data = wd; wr_nat = wn;
      rd0_addr = a0; rd1_addr = a1; op_sel = op; chk_en = ce;
      #1;
      e0 = f_read(a0);
      e1 = f_read(a1);
      chk((we && wa != 0 && wa == a0) ? "R4 bypass p0" : (a0 == 0 ? "R1 zero p0" : "R3 read p0"),
          {rd0_nat, rd0_data}, e0);
      chk((we && wa != 0 && wa == a1) ? "R4 bypass p1" : (a1 == 0 ? "R1 zero p1" : "R3 read p1"),
          {rd1_nat, rd1_data}, e1);
      chk("R5 combine", {res_nat, res_data}, {e0[DW] | e1[DW], f_comb(e0[DW-1:0], e1[DW-1:0], op)});
      chk("R7 region", {63'd0, rd0_stacked, rd1_stacked}, {63'd0, a0 >= 7'd32, a1 >= 7'd32});
      exp_exc   = we && (wa == '0);
      exp_fault = ce && (e0[DW] | e1[DW]);
      @(posedge clk);
      cyc++;
      if (we && wa != '0) begin
         m_val[wa] = wd;
         m_nat[wa] = wn;
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = $urandom(32'd20240611);
      for (int i = 0; i < NR; i++) begin m_val[i] = '0; m_nat[i] = 1'b0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R8 reset exc", {64'd0, wr_zero_exc}, '0);
      chk("R8 reset fault", {64'd0, nat_fault}, '0);
      rst_n = 1'b1;
      // R8: every entry reads zero after reset
      for (int a = 0; a < NR; a += 2) step(1'b0, '0, '0, 1'b0, AW'(a), AW'(a + 1), 2'd0, 1'b0);
      // R2: entry-0 write is refused and pulses the exception
      step(1'b1, 7'd0, 64'hDEAD_BEEF_0000_0001, 1'b1, 7'd0, 7'd0, 2'd0, 1'b1);
      step(1'b0, 7'd0, '0, 1'b0, 7'd0, 7'd5, 2'd0, 1'b0);
      step(1'b0, 7'd0, '0, 1'b0, 7'd0, 7'd0, 2'd0, 1'b0);
      // R3/R7: boundary entries 31, 32, 127
      step(1'b1, 7'd31, 64'h1111, 1'b0, 7'd1, 7'd2, 2'd0, 1'b0);
      step(1'b1, 7'd32, 64'h2222, 1'b1, 7'd31, 7'd32, 2'd1, 1'b1);
      step(1'b1, 7'd127, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 7'd31, 7'd127, 2'd0, 1'b1);
      step(1'b0, 7'd0, '0, 1'b0, 7'd127, 7'd32, 2'd0, 1'b1);
      // R4/R6: poisoned write bypassed into a checking consumer
      step(1'b1, 7'd40, 64'h5, 1'b1, 7'd40, 7'd31, 2'd2, 1'b1);
      step(1'b1, 7'd40, 64'h6, 1'b0, 7'd40, 7'd31, 2'd3, 1'b1);
      step(1'b0, 7'd0, '0, 1'b0, 7'd40, 7'd0, 2'd1, 1'b1);
      // constrained random
      for (int k = 0; k < 3000; k++) begin
         logic [AW-1:0] wa, a0, a1;
         wa = ($urandom % 10 == 0) ? 7'd0 : AW'($urandom % 48 + (($urandom % 2) ? 80 : 0));
         a0 = ($urandom % 3 == 0) ? wa : AW'($urandom);
         a1 = ($urandom % 4 == 0) ? wa : (($urandom % 8 == 0) ? 7'd0 : AW'($urandom));
         step($urandom % 3 != 0, wa, {$urandom, $urandom}, $urandom % 4 == 0,
              a0, a1, 2'($urandom), $urandom % 2 == 0);
      end
      step(1'b0, 7'd0, '0, 1'b0, 7'd0, 7'd0, 2'd0, 1'b0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule